// File: doc/BRIEF.md
# Display Coprocessor Loader and Run Control

This block sits between a host register interface and the instruction store of a raster-synchronized display coprocessor. The host sets an 11-bit byte pointer through two registers. It then loads program bytes into a 1024-word by 16-bit instruction RAM, one byte at a time or as byte pairs that land in memory as whole words. The RAM itself sits outside the block. The block drives its write port with a word address, a 16-bit data bus and two byte-lane enables.

The same control register selects one of four run modes. The block keeps the coprocessor's program pointer. The pointer steps forward each time the execution engine pulses an instruction-complete input. It can also return to word 0 when a mode is entered, when the list wraps, or when the raster reports the top-left pixel of a frame. Instruction decode and execution are outside this block.

Top module: `dcop_loader`

## Requirements
- R1: After reset the load pointer is 0, the run mode is 00 (stopped), the program pointer is 0, `running` is 0 and no RAM write is issued.
- R2: `host_sel` selects the target of a host write: 0 = pointer low byte (data bits 7:0 go to pointer bits 7:0), 1 = control (data bits 2:0 go to pointer bits 10:8, data bits 7:6 give the run mode, bits 5:3 are ignored), 2 = byte data, 3 = word data.
- R3: Every byte-data or word-data write advances the load pointer by one, wrapping from 0x7FF to 0x000. Pointer and control writes do not advance it.
- R4: A byte-data write produces exactly one RAM write in the next cycle, at word address pointer[10:1]. An even pointer enables only lane bits 15:8 (`ram_be` = 2'b10). An odd pointer enables only lane bits 7:0 (`ram_be` = 2'b01). The other half of the word is left untouched.
- R5: A word-data write at an even pointer only holds the byte and issues no RAM write. A word-data write at an odd pointer writes {held byte, new byte} to both lanes (`ram_be` = 2'b11) in the next cycle.
- R6: In mode 00 the program pointer does not move and `instr_done` is ignored. `running` is 1 in every other mode.
- R7: Entering mode 01 from another mode sets the program pointer to 0. Each `instr_done` then advances it by one, and it wraps from word 1023 to 0.
- R8: Entering mode 10 keeps the program pointer where it was. Execution resumes from there with the same advance and wrap.
- R9: Entering mode 11 sets the program pointer to 0. In mode 11 a `frame_origin` pulse sets it to 0 and takes priority over `instr_done`. In modes 01 and 10, `frame_origin` is ignored.
- R10: Writing the control register with the mode already in force leaves the program pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Target register of the host write |
| host_wdata | input | 8 | Host write data |
| instr_done | input | 1 | Execution engine finished the current instruction |
| frame_origin | input | 1 | Raster is at position (0,0) |
| ram_we | output | 1 | Instruction RAM write enable |
| ram_waddr | output | 10 | Instruction RAM word address |
| ram_wdata | output | 16 | Instruction RAM write data, bits 15:8 = even byte |
| ram_be | output | 2 | Lane enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| load_addr | output | 11 | Current byte load pointer |
| run_mode | output | 2 | Current run mode |
| prog_ptr | output | 10 | Program pointer (instruction word index) |
| running | output | 1 | Coprocessor mode is not stopped |

## Verification
The assertions check the following on every cycle: the one-step advance of the load pointer after each data write, single-lane enables on byte writes, the absence of a commit on even word writes and a full-word commit on odd ones, and a frozen program pointer in stop mode or on a same-mode rewrite. They also check the return to zero on a frame origin in mode 11.

Only the bench scenarios can show that the written values land at the right word with the right data across the whole 2 KB space. The same holds for the wrap at 0x7FF, the resume-versus-restart difference between modes 10 and 01, and the wrap of the program pointer after 1024 steps.

// File: rtl/dcop_pkg.sv
package dcop_pkg;

  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_LOOP   = 2'b01,
    MODE_RESUME = 2'b10,
    MODE_FRAME  = 2'b11
  } run_mode_e;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_CTRL    = 2'd1,
    SEL_BYTE    = 2'd2,
    SEL_WORD    = 2'd3
  } host_sel_e;

  // Lane enable for a single byte: even byte is the high lane
  function automatic logic [1:0] lane_of(input logic odd);
    return odd ? 2'b01 : 2'b10;
  endfunction

  // A mode change into a mode that starts from word 0 forces a restart
  function automatic logic mode_restarts(input run_mode_e cur, input run_mode_e nxt);
    return (nxt != cur) && nxt[0];
  endfunction

endpackage

// File: rtl/dcop_wr_path.sv
module dcop_wr_path
  import dcop_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  host_sel_e             wr_sel,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [ADDR_W-1:0]     addr_q,
  output logic                  ram_we,
  output logic [ADDR_W-2:0]     ram_waddr,
  output logic [2*BYTE_W-1:0]   ram_wdata,
  output logic [1:0]            ram_be
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic              byte_wr, word_wr, data_wr, word_even, word_odd;
  logic [ADDR_W-1:0] addr_d;
  logic [BYTE_W-1:0] hold_q;

  always_comb begin
    byte_wr   = wr_en && (wr_sel == SEL_BYTE);
    word_wr   = wr_en && (wr_sel == SEL_WORD);
    data_wr   = byte_wr || word_wr;
    word_even = word_wr && !addr_q[0];
    word_odd  = word_wr &&  addr_q[0];
    addr_d    = addr_q;
    if (wr_en && wr_sel == SEL_ADDR_LO) addr_d[BYTE_W-1:0] = wr_data;
    else if (wr_en && wr_sel == SEL_CTRL) addr_d[ADDR_W-1:BYTE_W] = wr_data[HI_W-1:0];
    else if (data_wr) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      hold_q    <= '0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
      ram_be    <= 2'b00;
    end else begin
      addr_q <= addr_d;
      if (word_even) hold_q <= wr_data;
      ram_we    <= byte_wr || word_odd;
      ram_waddr <= addr_q[ADDR_W-1:1];
      ram_wdata <= byte_wr ? {wr_data, wr_data} : {hold_q, wr_data};
      ram_be    <= byte_wr ? lane_of(addr_q[0]) : (word_odd ? 2'b11 : 2'b00);
    end
  end

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> ram_we && ($countones(ram_be) == 1));

  a_r5_even_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_even |=> !ram_we);

  a_r5_odd_commit: assert property (@(posedge clk) disable iff (!rst_n)
    word_odd |=> ram_we && ram_be == 2'b11 && ram_wdata[BYTE_W-1:0] == $past(wr_data));

endmodule

// File: rtl/dcop_run_ctl.sv
module dcop_run_ctl
  import dcop_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  run_mode_e       new_mode,
  input  logic            instr_done,
  input  logic            frame_origin,
  output run_mode_e       mode_q,
  output logic [PC_W-1:0] pc_q
);

  logic            restart, origin_hit, advance;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    restart    = ctl_wr && mode_restarts(mode_q, new_mode);
    origin_hit = (mode_q == MODE_FRAME) && frame_origin;
    advance    = (mode_q != MODE_STOP) && instr_done;
    if (restart || origin_hit) pc_d = '0;
    else if (advance)          pc_d = pc_q + 1'b1;
    else                       pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STOP;
      pc_q   <= '0;
    end else begin
      pc_q <= pc_d;
      if (ctl_wr) mode_q <= new_mode;
    end
  end

  a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && !ctl_wr) |=> $stable(pc_q));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && !origin_hit) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  a_r8_resume_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && new_mode == MODE_RESUME && !instr_done && !origin_hit) |=> $stable(pc_q));

  a_r9_origin_zero: assert property (@(posedge clk) disable iff (!rst_n)
    origin_hit |=> pc_q == '0);

  a_r10_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && new_mode == mode_q && !instr_done && !origin_hit) |=> $stable(pc_q));

endmodule

// File: rtl/dcop_loader.sv
module dcop_loader
  import dcop_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [7:0]        host_wdata,
  input  logic              instr_done,
  input  logic              frame_origin,
  output logic              ram_we,
  output logic [ADDR_W-2:0] ram_waddr,
  output logic [15:0]       ram_wdata,
  output logic [1:0]        ram_be,
  output logic [ADDR_W-1:0] load_addr,
  output logic [1:0]        run_mode,
  output logic [ADDR_W-2:0] prog_ptr,
  output logic              running
);

  localparam int BYTE_W = 8;
  localparam int PC_W   = ADDR_W - 1;

  host_sel_e sel;
  run_mode_e mode_w;
  logic      ctl_wr;

  assign sel    = host_sel_e'(host_sel);
  assign ctl_wr = host_wr && (sel == SEL_CTRL);

  dcop_wr_path #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_sel(sel), .wr_data(host_wdata),
    .addr_q(load_addr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .ram_be(ram_be)
  );

  dcop_run_ctl #(.PC_W(PC_W)) u_run (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .new_mode(run_mode_e'(host_wdata[7:6])),
    .instr_done(instr_done), .frame_origin(frame_origin),
    .mode_q(mode_w), .pc_q(prog_ptr)
  );

  assign run_mode = mode_w;
  assign running  = (mode_w != MODE_STOP);

  a_r6_running_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr) |-> running == ($past(host_wdata[7:6]) != 2'b00));

endmodule

// File: tb/sim_dcop_loader.sv
module sim_dcop_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic        instr_done = 1'b0;
  logic        frame_origin = 1'b0;
  logic        ram_we;
  logic [9:0]  ram_waddr;
  logic [15:0] ram_wdata;
  logic [1:0]  ram_be;
  logic [10:0] load_addr;
  logic [1:0]  run_mode;
  logic [9:0]  prog_ptr;
  logic        running;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dcop_loader u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .instr_done(instr_done), .frame_origin(frame_origin),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_be(ram_be),
    .load_addr(load_addr), .run_mode(run_mode), .prog_ptr(prog_ptr), .running(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic step(input logic dn, input logic org);
    instr_done = dn; frame_origin = org;
    @(negedge clk);
    instr_done = 1'b0; frame_origin = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    hw(2'd1, {m, 6'b000000});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(load_addr == 0, "R1 load_addr", load_addr, 0);
    chk(run_mode == 0,  "R1 run_mode", run_mode, 0);
    chk(prog_ptr == 0,  "R1 prog_ptr", prog_ptr, 0);
    chk(!running,       "R1 running", running, 0);
    chk(!ram_we,        "R1 ram_we", ram_we, 0);

    // R3/R4 byte sweep over the whole space, ending in a wrap
    for (int i = 0; i < 2048; i++) begin
      logic [7:0] d;
      d = i[7:0] ^ 8'h5A;
      hw(2'd2, d);
      chk(ram_we, "R4 byte we", ram_we, 1);
      chk(ram_waddr == i[10:1], "R4 byte waddr", ram_waddr, i >> 1);
      if (i[0]) begin
        chk(ram_be == 2'b01, "R4 odd lane", ram_be, 1);
        chk(ram_wdata[7:0] == d, "R4 odd data", ram_wdata[7:0], d);
      end else begin
        chk(ram_be == 2'b10, "R4 even lane", ram_be, 2);
        chk(ram_wdata[15:8] == d, "R4 even data", ram_wdata[15:8], d);
      end
      chk(load_addr == ((i + 1) % 2048), "R3 advance", load_addr, (i + 1) % 2048);
    end

    // R5 paired writes across the top of the space
    hw(2'd0, 8'hF0);
    chk(load_addr == 11'h0F0, "R2 low byte", load_addr, 11'h0F0);
    hw(2'd1, 8'h07);
    chk(load_addr == 11'h7F0, "R2 high bits", load_addr, 11'h7F0);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] hi, lo;
      int a;
      hi = 8'(k * 3 + 1);
      lo = 8'(k) ^ 8'hC3;
      a  = (11'h7F0 + 2 * k) % 2048;
      hw(2'd3, hi);
      chk(!ram_we, "R5 even holds", ram_we, 0);
      chk(load_addr == ((a + 1) % 2048), "R3 word advance", load_addr, (a + 1) % 2048);
      hw(2'd3, lo);
      chk(ram_we && ram_be == 2'b11, "R5 odd commit", {ram_we, ram_be}, 7);
      chk(ram_wdata == {hi, lo}, "R5 word data", ram_wdata, {hi, lo});
      chk(ram_waddr == 10'(a >> 1), "R5 word addr", ram_waddr, a >> 1);
    end
    chk(load_addr == 11'h010, "R3 word wrap", load_addr, 11'h010);

    // R2 ignored control bits 5:3, mode field
    hw(2'd1, 8'b00_111_101);
    chk(load_addr == 11'h510, "R2 ctrl hi", load_addr, 11'h510);
    chk(run_mode == 0, "R2 mode kept 00", run_mode, 0);
    hw(2'd0, 8'h3C);
    chk(load_addr == 11'h53C, "R2 lo keeps hi", load_addr, 11'h53C);

    // R6 stopped
    step(1, 0); step(1, 1);
    chk(prog_ptr == 0, "R6 stop ignores done", prog_ptr, 0);
    chk(!running, "R6 running low", running, 0);

    // R7 loop mode
    set_mode(2'b01);
    chk(running && run_mode == 1, "R7 mode 01", run_mode, 1);
    chk(load_addr == 11'h03C, "R2 ctrl write hi", load_addr, 11'h03C);
    for (int n = 0; n < 5; n++) step(1, 0);
    chk(prog_ptr == 5, "R7 advance", prog_ptr, 5);
    set_mode(2'b01);
    chk(prog_ptr == 5, "R10 same mode", prog_ptr, 5);
    step(0, 1);
    chk(prog_ptr == 5, "R9 origin ignored in 01", prog_ptr, 5);

    // R8 resume
    set_mode(2'b10);
    chk(prog_ptr == 5, "R8 resume keeps", prog_ptr, 5);
    step(1, 1);
    chk(prog_ptr == 6, "R8 advance, R9 origin ignored", prog_ptr, 6);
    set_mode(2'b00);
    step(1, 0);
    chk(prog_ptr == 6, "R6 stop holds", prog_ptr, 6);
    set_mode(2'b10);
    chk(prog_ptr == 6, "R8 resume from stop", prog_ptr, 6);

    // R7 restart and wrap
    set_mode(2'b01);
    chk(prog_ptr == 0, "R7 restart", prog_ptr, 0);
    for (int n = 0; n < 1030; n++) step(1, 0);
    chk(prog_ptr == 6, "R7 wrap", prog_ptr, 6);

    // R9 frame mode
    set_mode(2'b11);
    chk(prog_ptr == 0, "R9 enter 11", prog_ptr, 0);
    for (int n = 0; n < 3; n++) step(1, 0);
    chk(prog_ptr == 3, "R9 advance", prog_ptr, 3);
    step(0, 1);
    chk(prog_ptr == 0, "R9 origin zero", prog_ptr, 0);
    step(1, 0); step(1, 0);
    step(1, 1);
    chk(prog_ptr == 0, "R9 origin beats done", prog_ptr, 0);
    step(1, 0); step(1, 0);
    set_mode(2'b11);
    chk(prog_ptr == 2, "R10 same mode 11", prog_ptr, 2);

    finish_run();
  end

endmodule